// File: doc/BRIEF.md
# DMA Channel Action Controller

This block is the per-channel control state machine of a descriptor-driven DMA engine. Software issues a two-bit action command (Clear, Go, Pause or Halt) over a valid/ready command port. The controller checks that the command is legal from its present state and applies it. It then copies the value into a separate last-action register, which software polls until it matches the command it sent. While running, the controller walks a ring of buffer descriptors. It counts data beats reported by the data path against each descriptor's length and advances a current-buffer index. It also keeps per-descriptor used, complete and invalid flags.

The engine overwrites the action register with Halt on its own in two cases: when a finished buffer carries its stop bit, or when the current descriptor is not marked valid. A Clear flushes the FIFO over a fixed number of cycles and zeroes the index, the offset counter and the status flags. The Clear is echoed into last-action only after the flush ends. On the command port, ready is held low for the whole flush, so a new command waits in place and is neither lost nor reordered; it is taken on the first cycle that ready returns high. Each descriptor occupies a 16-byte slot, and the controller presents the byte offset of the current slot within the channel's register window.

Top module: `dma_chan_ctrl`

## Requirements
- R1: Action codes are Clear=0, Go=1, Pause=2, Halt=3. After reset, action_q and last_action_q read 0, cur_buf is 0, xfer_en is 0 and cmd_ready is 1.
- R2: A legal non-Clear command accepted on a rising edge (cmd_valid and cmd_ready both high) appears in action_q and in last_action_q after that same edge.
- R3: An accepted Clear sets action_q to 0 and drives cmd_ready low and fifo_flush high for CLR_CYCLES cycles. It zeroes cur_buf, buf_offset and all status flags. last_action_q becomes 0 only CLR_CYCLES edges after acceptance.
- R4: Illegal commands are ignored, and neither action_q nor last_action_q changes. Halt written by software is illegal in every state. From Halt only Clear is legal. Pause is legal only from Go or Pause.
- R5: While paused, xfer_en is 0, beats are ignored, and cur_buf and buf_offset keep their values. Go resumes from that point.
- R6: uf_flag and of_flag latch a pulse on fifo_uf and fifo_of in any state, Pause included. Only a Clear resets them.
- R7: Each beat taken while xfer_en is high sets the used bit of the current descriptor and increments buf_offset. The beat that brings the count to the descriptor's length sets its done bit, returns buf_offset to 0 and advances cur_buf. cur_buf wraps from NUM_DESC-1 to 0.
- R8: desc_offset equals 0x10 + 0x10 * cur_buf.
- R9: When a buffer whose desc_stop bit is set completes, action_q and last_action_q both become 3 (Halt) on the same edge.
- R10: In Go, if desc_ok of the current descriptor is 0, the next edge sets its bad bit and sets action_q and last_action_q to 3.
- R11: xfer_en is 1 only in Go with the current descriptor valid.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cmd_valid | input | 1 | Command present |
| cmd_ready | output | 1 | Command can be taken (low during a flush) |
| cmd_action | input | 2 | Requested action code |
| action_q | output | 2 | Current action register |
| last_action_q | output | 2 | Echo of the last completed action |
| desc_ok | input | NUM_DESC | Valid bit of each descriptor's control word |
| desc_stop | input | NUM_DESC | Halt-on-completion bit of each descriptor |
| desc_len | input | NUM_DESC*LEN_W | Length in beats of each descriptor, descriptor 0 in the low bits |
| beat | input | 1 | Data path moved one word |
| xfer_en | output | 1 | Data path may move words |
| cur_buf | output | IDX_W | Current descriptor index |
| buf_offset | output | LEN_W | Beats done in the current buffer |
| desc_offset | output | DOFS_W | Byte offset of the current descriptor slot |
| fifo_flush | output | 1 | FIFO flush in progress |
| fifo_uf | input | 1 | FIFO underflow event |
| fifo_of | input | 1 | FIFO overflow event |
| uf_flag | output | 1 | Sticky underflow status |
| of_flag | output | 1 | Sticky overflow status |
| used_flags | output | NUM_DESC | Per-descriptor used status |
| done_flags | output | NUM_DESC | Per-descriptor complete status |
| bad_flags | output | NUM_DESC | Per-descriptor invalid status |

## Verification
A wrong action state shows up at xfer_en and action_q on the first edge after the command. A missed echo shows on last_action_q one edge after a non-Clear command, or CLR_CYCLES edges after a Clear. An offset counter that is off by one moves cur_buf, done_flags and desc_offset one beat early or late, and every later buffer boundary in the ring then shifts too. A halt that is not forced leaves xfer_en high past a stop buffer or an invalid slot, and this is visible on the next edge.

// File: rtl/dma_act_pkg.sv
package dma_act_pkg;

  typedef enum logic [1:0] {
    ACT_CLEAR = 2'd0,
    ACT_GO    = 2'd1,
    ACT_PAUSE = 2'd2,
    ACT_HALT  = 2'd3
  } act_e;

  // Software may never request Halt; Halt only exits through Clear;
  // Pause needs a running or already paused channel.
  function automatic logic cmd_legal(input act_e cur, input act_e req);
    logic ok;
    case (req)
      ACT_CLEAR: ok = 1'b1;
      ACT_GO:    ok = (cur != ACT_HALT);
      ACT_PAUSE: ok = (cur == ACT_GO) || (cur == ACT_PAUSE);
      default:   ok = 1'b0;
    endcase
    return ok;
  endfunction

endpackage

// File: rtl/dma_act_fsm.sv
module dma_act_fsm
  import dma_act_pkg::*;
#(
  parameter int CLR_CYCLES = 4
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       cmd_valid,
  output logic       cmd_ready,
  input  logic [1:0] cmd_action,
  input  logic       halt_req,
  output logic [1:0] action_q,
  output logic [1:0] last_q,
  output logic       run,
  output logic       clr_start,
  output logic       flushing
);

  localparam int CNT_W = (CLR_CYCLES > 1) ? $clog2(CLR_CYCLES) : 1;

  act_e             act_r;
  act_e             last_r;
  act_e             req;
  logic             flush_r;
  logic [CNT_W-1:0] cnt_r;
  logic             fire;
  logic             legal;

  assign req       = act_e'(cmd_action);
  assign cmd_ready = !flush_r;
  assign fire      = cmd_valid && cmd_ready;
  assign legal     = cmd_legal(act_r, req);
  assign clr_start = fire && (req == ACT_CLEAR);
  assign run       = (act_r == ACT_GO) && !flush_r;
  assign flushing  = flush_r;
  assign action_q  = act_r;
  assign last_q    = last_r;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      act_r   <= ACT_CLEAR;
      last_r  <= ACT_CLEAR;
      flush_r <= 1'b0;
      cnt_r   <= '0;
    end else if (clr_start) begin
      act_r   <= ACT_CLEAR;
      flush_r <= 1'b1;
      cnt_r   <= CNT_W'(CLR_CYCLES - 1);
    end else begin
      if (flush_r) begin
        if (cnt_r == '0) begin
          flush_r <= 1'b0;
          last_r  <= ACT_CLEAR;
        end else begin
          cnt_r <= cnt_r - 1'b1;
        end
      end
      if (halt_req) begin
        act_r  <= ACT_HALT;
        last_r <= ACT_HALT;
      end else if (fire && legal) begin
        act_r  <= req;
        last_r <= req;
      end
    end
  end

  // R4
  halt_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (act_r == ACT_HALT && fire && req != ACT_CLEAR) |=> (act_r == ACT_HALT));

  // R3
  flush_echo_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (flush_r && cnt_r == '0) |=> (last_r == ACT_CLEAR && cmd_ready));

  // R2
  echo_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (fire && legal && req != ACT_CLEAR && !halt_req) |=> (last_r == $past(req)));

endmodule

// File: rtl/dma_desc_walker.sv
module dma_desc_walker #(
  parameter int NUM_DESC = 4,
  parameter int LEN_W    = 8,
  localparam int IDX_W   = (NUM_DESC > 1) ? $clog2(NUM_DESC) : 1,
  localparam int DOFS_W  = $clog2(16 * (NUM_DESC + 1))
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      run,
  input  logic                      clr,
  input  logic [NUM_DESC-1:0]       desc_ok,
  input  logic [NUM_DESC-1:0]       desc_stop,
  input  logic [NUM_DESC*LEN_W-1:0] desc_len,
  input  logic                      beat,
  output logic                      xfer_en,
  output logic                      halt_req,
  output logic [IDX_W-1:0]          cur_buf,
  output logic [LEN_W-1:0]          offset,
  output logic [DOFS_W-1:0]         desc_ofs,
  output logic [NUM_DESC-1:0]       used_q,
  output logic [NUM_DESC-1:0]       done_q,
  output logic [NUM_DESC-1:0]       bad_q
);

  logic [LEN_W-1:0] len_arr [NUM_DESC];
  logic [IDX_W-1:0] cur_r;
  logic [IDX_W-1:0] nxt_idx;
  logic [LEN_W-1:0] off_r;
  logic [LEN_W-1:0] cur_len;
  logic             cur_ok;
  logic             step;
  logic             last_beat;
  logic             invalid;

  for (genvar g = 0; g < NUM_DESC; g++) begin : g_len
    assign len_arr[g] = desc_len[g*LEN_W +: LEN_W];
  end

  assign cur_len   = len_arr[cur_r];
  assign cur_ok    = desc_ok[cur_r];
  assign xfer_en   = run && cur_ok;
  assign step      = xfer_en && beat;
  assign last_beat = step && (off_r == cur_len - 1'b1);
  assign invalid   = run && !cur_ok;
  assign halt_req  = invalid || (last_beat && desc_stop[cur_r]);
  assign nxt_idx   = (cur_r == IDX_W'(NUM_DESC - 1)) ? '0 : cur_r + 1'b1;
  assign cur_buf   = cur_r;
  assign offset    = off_r;
  assign desc_ofs  = DOFS_W'(16) + (DOFS_W'(cur_r) << 4);

  always_ff @(posedge clk) begin
    if (!rst_n || clr) begin
      cur_r <= '0;
      off_r <= '0;
    end else if (last_beat) begin
      cur_r <= nxt_idx;
      off_r <= '0;
    end else if (step) begin
      off_r <= off_r + 1'b1;
    end
  end

  for (genvar g = 0; g < NUM_DESC; g++) begin : g_flag
    logic hit;
    assign hit = (cur_r == IDX_W'(g));
    always_ff @(posedge clk) begin
      if (!rst_n || clr) begin
        used_q[g] <= 1'b0;
        done_q[g] <= 1'b0;
        bad_q[g]  <= 1'b0;
      end else begin
        if (step && hit)      used_q[g] <= 1'b1;
        if (last_beat && hit) done_q[g] <= 1'b1;
        if (invalid && hit)   bad_q[g]  <= 1'b1;
      end
    end
  end

  // R5
  idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!run && !clr) |=> ($stable(cur_r) && $stable(off_r)));

  // R7
  wrap_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ($unsigned(cur_r) < NUM_DESC));

  // R10
  bad_mark_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (invalid && !clr) |=> bad_q[$past(cur_r)]);

endmodule

// File: rtl/dma_evt_flags.sv
module dma_evt_flags #(
  parameter int NUM_EVT = 2
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               clr,
  input  logic [NUM_EVT-1:0] evt_in,
  output logic [NUM_EVT-1:0] flag_q
);

  for (genvar g = 0; g < NUM_EVT; g++) begin : g_evt
    always_ff @(posedge clk) begin
      if (!rst_n || clr)  flag_q[g] <= 1'b0;
      else if (evt_in[g]) flag_q[g] <= 1'b1;
    end

    // R6
    evt_latch_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (evt_in[g] && !clr) |=> flag_q[g]);
  end

endmodule

// File: rtl/dma_chan_ctrl.sv
module dma_chan_ctrl #(
  parameter int NUM_DESC   = 4,
  parameter int LEN_W      = 8,
  parameter int CLR_CYCLES = 4,
  localparam int IDX_W     = (NUM_DESC > 1) ? $clog2(NUM_DESC) : 1,
  localparam int DOFS_W    = $clog2(16 * (NUM_DESC + 1))
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      cmd_valid,
  output logic                      cmd_ready,
  input  logic [1:0]                cmd_action,
  output logic [1:0]                action_q,
  output logic [1:0]                last_action_q,
  input  logic [NUM_DESC-1:0]       desc_ok,
  input  logic [NUM_DESC-1:0]       desc_stop,
  input  logic [NUM_DESC*LEN_W-1:0] desc_len,
  input  logic                      beat,
  output logic                      xfer_en,
  output logic [IDX_W-1:0]          cur_buf,
  output logic [LEN_W-1:0]          buf_offset,
  output logic [DOFS_W-1:0]         desc_offset,
  output logic                      fifo_flush,
  input  logic                      fifo_uf,
  input  logic                      fifo_of,
  output logic                      uf_flag,
  output logic                      of_flag,
  output logic [NUM_DESC-1:0]       used_flags,
  output logic [NUM_DESC-1:0]       done_flags,
  output logic [NUM_DESC-1:0]       bad_flags
);

  logic       run;
  logic       clr_start;
  logic       halt_req;
  logic [1:0] evt_flags;

  dma_act_fsm #(.CLR_CYCLES(CLR_CYCLES)) u_fsm (
    .clk        (clk),
    .rst_n      (rst_n),
    .cmd_valid  (cmd_valid),
    .cmd_ready  (cmd_ready),
    .cmd_action (cmd_action),
    .halt_req   (halt_req),
    .action_q   (action_q),
    .last_q     (last_action_q),
    .run        (run),
    .clr_start  (clr_start),
    .flushing   (fifo_flush)
  );

  dma_desc_walker #(.NUM_DESC(NUM_DESC), .LEN_W(LEN_W)) u_walk (
    .clk       (clk),
    .rst_n     (rst_n),
    .run       (run),
    .clr       (clr_start),
    .desc_ok   (desc_ok),
    .desc_stop (desc_stop),
    .desc_len  (desc_len),
    .beat      (beat),
    .xfer_en   (xfer_en),
    .halt_req  (halt_req),
    .cur_buf   (cur_buf),
    .offset    (buf_offset),
    .desc_ofs  (desc_offset),
    .used_q    (used_flags),
    .done_q    (done_flags),
    .bad_q     (bad_flags)
  );

  dma_evt_flags #(.NUM_EVT(2)) u_evt (
    .clk    (clk),
    .rst_n  (rst_n),
    .clr    (clr_start),
    .evt_in ({fifo_of, fifo_uf}),
    .flag_q (evt_flags)
  );

  assign uf_flag = evt_flags[0];
  assign of_flag = evt_flags[1];

  // R11
  xfer_go_chk: assert property (@(posedge clk) disable iff (!rst_n)
    xfer_en |-> (action_q == 2'd1 && !fifo_flush));

endmodule

// File: tb/dma_chan_ctrl_tb.sv
`timescale 1ns/1ps
module dma_chan_ctrl_tb;

  localparam int ND  = 4;
  localparam int LW  = 8;
  localparam int CLR = 4;
  localparam int IW  = 2;
  localparam int DW  = 7;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          cmd_valid = 1'b0;
  logic          cmd_ready;
  logic [1:0]    cmd_action = 2'd0;
  logic [1:0]    action_q, last_action_q;
  logic [ND-1:0] desc_ok = 4'b1111;
  logic [ND-1:0] desc_stop = 4'b0000;
  logic [ND*LW-1:0] desc_len = {8'd2, 8'd3, 8'd1, 8'd2};
  logic          beat = 1'b0;
  logic          xfer_en;
  logic [IW-1:0] cur_buf;
  logic [LW-1:0] buf_offset;
  logic [DW-1:0] desc_offset;
  logic          fifo_flush;
  logic          fifo_uf = 1'b0, fifo_of = 1'b0;
  logic          uf_flag, of_flag;
  logic [ND-1:0] used_flags, done_flags, bad_flags;

  int checks = 0;
  int fails = 0;
  int exp_q[$];
  logic mon_on = 1'b0;

  always #2.5 clk = ~clk;

  dma_chan_ctrl #(.NUM_DESC(ND), .LEN_W(LW), .CLR_CYCLES(CLR)) u_dut (
    .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_ready(cmd_ready),
    .cmd_action(cmd_action), .action_q(action_q), .last_action_q(last_action_q),
    .desc_ok(desc_ok), .desc_stop(desc_stop), .desc_len(desc_len), .beat(beat),
    .xfer_en(xfer_en), .cur_buf(cur_buf), .buf_offset(buf_offset),
    .desc_offset(desc_offset), .fifo_flush(fifo_flush), .fifo_uf(fifo_uf),
    .fifo_of(fifo_of), .uf_flag(uf_flag), .of_flag(of_flag),
    .used_flags(used_flags), .done_flags(done_flags), .bad_flags(bad_flags)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  // Scoreboard monitor: each change of last_action_q pops one expected echo (R2)
  initial begin : monitor
    logic [1:0] prev;
    wait (mon_on);
    prev = last_action_q;
    forever begin
      @(negedge clk);
      if (last_action_q !== prev) begin
        checks++;
        if (exp_q.size() == 0) begin
          fails++;
          $display("FAIL R2 echo actual=%0d expected=none", last_action_q);
        end else begin
          int e;
          e = exp_q.pop_front();
          if (last_action_q !== 2'(e)) begin
            fails++;
            $display("FAIL R2 echo actual=%0d expected=%0d", last_action_q, e);
          end
        end
        prev = last_action_q;
      end
    end
  end

  task automatic send(input logic [1:0] a);
    @(negedge clk);
    while (!cmd_ready) @(negedge clk);
    cmd_valid  = 1'b1;
    cmd_action = a;
    @(negedge clk);
    cmd_valid = 1'b0;
  endtask

  task automatic run_beats(input int n);
    @(negedge clk);
    beat = 1'b1;
    repeat (n) @(negedge clk);
    beat = 1'b0;
  endtask

  task automatic main_seq();
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1 action", action_q, 0);
    chk("R1 last", last_action_q, 0);
    chk("R1 cur_buf", cur_buf, 0);
    chk("R1 xfer_en", xfer_en, 0);
    chk("R1 ready", cmd_ready, 1);
    chk("R8 ofs0", desc_offset, 7'h10);
    mon_on = 1'b1;

    exp_q.push_back(1);
    send(2'd1);
    chk("R2 go", action_q, 1);
    chk("R11 xfer on", xfer_en, 1);
    run_beats(1);
    chk("R7 offset", buf_offset, 1);
    chk("R7 used", used_flags, 4'b0001);
    run_beats(1);
    chk("R7 advance", cur_buf, 1);
    chk("R7 done", done_flags, 4'b0001);
    chk("R8 ofs1", desc_offset, 7'h20);

    exp_q.push_back(2);
    send(2'd2);
    chk("R5 pause", action_q, 2);
    chk("R11 xfer paused", xfer_en, 0);
    run_beats(3);
    chk("R5 cur hold", cur_buf, 1);
    chk("R5 off hold", buf_offset, 0);
    @(negedge clk); fifo_uf = 1'b1;
    @(negedge clk); fifo_uf = 1'b0;
    chk("R6 uf in pause", uf_flag, 1);
    chk("R6 of idle", of_flag, 0);
    send(2'd3);
    chk("R4 sw halt", action_q, 2);

    exp_q.push_back(1);
    send(2'd1);
    run_beats(1);
    chk("R7 len1", cur_buf, 2);
    @(negedge clk); fifo_of = 1'b1;
    @(negedge clk); fifo_of = 1'b0;
    chk("R6 of", of_flag, 1);
    run_beats(3);
    chk("R7 len3", cur_buf, 3);
    desc_ok = 4'b1110;
    exp_q.push_back(3);
    run_beats(2);
    chk("R7 wrap", cur_buf, 0);
    chk("R7 all done", done_flags, 4'b1111);
    @(negedge clk);
    chk("R10 halt", action_q, 3);
    chk("R10 bad", bad_flags, 4'b0001);
    chk("R11 xfer halted", xfer_en, 0);

    send(2'd1);
    chk("R4 go in halt", action_q, 3);
    send(2'd2);
    chk("R4 pause in halt", action_q, 3);
    chk("R4 last kept", last_action_q, 3);

    exp_q.push_back(0);
    send(2'd0);
    chk("R3 ready low", cmd_ready, 0);
    chk("R3 flush", fifo_flush, 1);
    chk("R3 action", action_q, 0);
    chk("R3 cur", cur_buf, 0);
    chk("R3 flags", {used_flags, done_flags, bad_flags}, 0);
    chk("R6 cleared", {uf_flag, of_flag}, 0);
    repeat (CLR - 1) @(negedge clk);
    chk("R3 last held", last_action_q, 3);
    @(negedge clk);
    chk("R3 last clear", last_action_q, 0);
    chk("R3 ready back", cmd_ready, 1);
    chk("R3 flush off", fifo_flush, 0);

    desc_ok   = 4'b1111;
    desc_stop = 4'b0001;
    exp_q.push_back(1);
    send(2'd1);
    exp_q.push_back(3);
    run_beats(2);
    chk("R9 halt", action_q, 3);
    chk("R9 last", last_action_q, 3);
    chk("R9 cur", cur_buf, 1);
    chk("R9 done", done_flags, 4'b0001);

    exp_q.push_back(0);
    send(2'd0);
    repeat (CLR) @(negedge clk);
    chk("R3 clear again", last_action_q, 0);
    send(2'd2);
    chk("R4 pause from clear", action_q, 0);
    chk("R4 pause last", last_action_q, 0);
    repeat (2) @(negedge clk);
    chk("R2 echo queue empty", exp_q.size(), 0);
  endtask

  initial begin
    fork
      main_seq();
      begin
        repeat (20000) @(posedge clk);
        fails++;
        $display("FAIL watchdog actual=timeout expected=finish");
      end
    join_any
    disable fork;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

endmodule